// File: doc/BRIEF.md
# Fault Symptom Gatherer

This block sits beside a processor core and turns raw fault symptoms into a compact feature vector for a downstream fault classifier. It watches three kinds of input. The first is fatal-trap events, each with an 8-bit trap code and the core's current trap-depth value. The second is pulses that flag abnormally long stretches of privileged execution, called high-activity pulses. The third is a periodic window strobe. Over each window it counts how often each of seven tracked symptoms arrives. It also keeps the deepest trap nesting seen in that window.

When the window strobe fires, the counts and the nesting depth are latched into an 8-element output vector. The counters then start again from zero. The vector holds until the next strobe.

The block also checks every trap code against a small programmable table. Each table entry pairs a trap code with the ID of the one hardware structure that can raise it. On a match, the block reports a hit and the structure ID right away. This lets the faulty structure be located without waiting for the classifier. Structure IDs are: 0 = instruction decoder, 1 = address-generation unit, 2 = integer/floating-point execution unit.

Top module: `symptom_gather`

## Requirements
- R1: While and right after reset, these outputs are zero: `feat_vec`, `feat_valid`, `ded_hit` and `ded_sid`. Every table entry is invalid after reset.
- R2: A cycle with `trap_valid` high adds one to element k of the open window's count when `trap_code` equals tracked code k. The tracked codes are: element 0 = 0x10, 1 = 0x34, 2 = 0x28, 3 = 0x30, 4 = 0x02, 5 = 0x05. Any other code adds to no element.
- R3: A cycle with `busy_pulse` high adds one to element 6. A trap and a busy pulse in the same cycle are both counted.
- R4: Each count saturates at 255 and never wraps.
- R5: A cycle with `win_end` high closes the window. Events in that same cycle belong to the closing window. On the next clock edge, `feat_vec` takes the closing window's values and `feat_valid` is high for exactly that one cycle. The next window starts from zero counts.
- R6: Element 7 is the largest `trap_depth` among fatal traps in the window, with values above 6 read as 6. Element 7 is 0 when the window had no trap. Traps of any code count toward it.
- R7: `feat_vec` keeps its value in every cycle that does not follow a `win_end`.
- R8: When `tbl_we` is high, the table entry at `tbl_idx` takes `tbl_code`, `tbl_sid` and the valid flag `tbl_valid`. A trap in the same cycle is looked up against the old contents.
- R9: A trap whose code matches a valid entry gives `ded_hit` = 1 and that entry's structure ID on `ded_sid` on the next edge. If several entries match, the lowest index wins.
- R10: In a cycle after no trap, or after a trap that matches no valid entry, `ded_hit` = 0 and `ded_sid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | A fatal trap is raised this cycle |
| trap_code | input | 8 | Type code of the trap |
| trap_depth | input | 3 | Core trap-depth value at the trap |
| busy_pulse | input | 1 | High-activity symptom this cycle |
| win_end | input | 1 | Closes the current counting window |
| tbl_we | input | 1 | Write enable for the dedicated-trap table |
| tbl_idx | input | 3 | Table entry to write |
| tbl_code | input | 8 | Trap code stored in the entry |
| tbl_sid | input | 2 | Structure ID stored in the entry |
| tbl_valid | input | 1 | Valid flag stored in the entry |
| feat_vec | output | 64 | Eight 8-bit elements; element i is at bits [8i+7:8i] |
| feat_valid | output | 1 | One-cycle pulse when `feat_vec` is refreshed |
| ded_hit | output | 1 | The previous cycle's trap matched a table entry |
| ded_sid | output | 2 | Structure ID of the matching entry |

## Verification
Every result appears one clock edge after the cycle that causes it:
- `ded_hit` and `ded_sid` appear one edge after the trap.
- `feat_valid` and the new `feat_vec` appear one edge after `win_end`.
- A count change becomes visible only through the vector, one edge after the strobe that closes the window.

The bench drives each input set at a falling edge and lets one rising edge pass. It then updates its reference model for that edge and compares every output at the next falling edge. So each check lands in the one cycle where the registered result is due. Directed cases cover saturation, depth clamping, duplicate table entries, and a table write in the same cycle as a trap. Constrained random traffic covers the rest.

// File: rtl/symg_pkg.sv
package symg_pkg;
  localparam int TYPE_W  = 8;
  localparam int SID_W   = 2;
  localparam int LVL_W   = 3;
  localparam int MAX_LVL = 6;
  localparam int NTRAP   = 6;
  localparam int NSYM    = NTRAP + 1;
  localparam int NFEAT   = NSYM + 1;
  // Tracked trap codes; index k feeds feature element k.
  localparam logic [NTRAP-1:0][TYPE_W-1:0] TRACKED =
    {8'h05, 8'h02, 8'h30, 8'h28, 8'h34, 8'h10};
endpackage

// File: rtl/symg_sat_counter.sv
module symg_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nx
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_comb cnt_nx = (inc && cnt_q != MAXV) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else            cnt_q <= cnt_nx;
  end

  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAXV && !clr) |=> cnt_q == MAXV);
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/symg_nest_track.sv
module symg_nest_track
  import symg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  logic [LVL_W-1:0] depth,
  input  logic             clr,
  output logic [LVL_W-1:0] lvl_q,
  output logic [LVL_W-1:0] lvl_nx
);
  logic [LVL_W-1:0] d_clamp;

  always_comb begin
    d_clamp = (depth > LVL_W'(MAX_LVL)) ? LVL_W'(MAX_LVL) : depth;
    lvl_nx  = (ev && d_clamp > lvl_q) ? d_clamp : lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) lvl_q <= '0;
    else            lvl_q <= lvl_nx;
  end

  assert_lvl_bound_R6: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= LVL_W'(MAX_LVL));
  assert_lvl_mono_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> lvl_q >= $past(lvl_q));
endmodule

// File: rtl/symg_ded_cam.sv
module symg_ded_cam
  import symg_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [TYPE_W-1:0] wcode,
  input  logic [SID_W-1:0]  wsid,
  input  logic              wvalid,
  input  logic              look_en,
  input  logic [TYPE_W-1:0] look_code,
  output logic              hit_q,
  output logic [SID_W-1:0]  sid_q
);
  logic              ent_v [DEPTH];
  logic [TYPE_W-1:0] ent_c [DEPTH];
  logic [SID_W-1:0]  ent_s [DEPTH];
  logic              m_hit;
  logic [SID_W-1:0]  m_sid;

  // Scan downward so the lowest matching index is the last assignment.
  always_comb begin
    m_hit = 1'b0;
    m_sid = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ent_v[i] && ent_c[i] == look_code) begin
        m_hit = 1'b1;
        m_sid = ent_s[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      ent_c[waddr] <= wcode;
      ent_s[waddr] <= wsid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ent_v[i] <= 1'b0;
    end else if (we) begin
      ent_v[waddr] <= wvalid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      sid_q <= '0;
    end else begin
      hit_q <= look_en && m_hit;
      sid_q <= (look_en && m_hit) ? m_sid : '0;
    end
  end

  assert_hit_after_trap_R9: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(look_en));
  assert_sid_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !hit_q |-> sid_q == '0);
endmodule

// File: rtl/symptom_gather.sv
module symptom_gather
  import symg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TBL_DEPTH = 8,
  localparam int AW = $clog2(TBL_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   trap_valid,
  input  logic [TYPE_W-1:0]      trap_code,
  input  logic [LVL_W-1:0]       trap_depth,
  input  logic                   busy_pulse,
  input  logic                   win_end,
  input  logic                   tbl_we,
  input  logic [AW-1:0]          tbl_idx,
  input  logic [TYPE_W-1:0]      tbl_code,
  input  logic [SID_W-1:0]       tbl_sid,
  input  logic                   tbl_valid,
  output logic [NFEAT*CNT_W-1:0] feat_vec,
  output logic                   feat_valid,
  output logic                   ded_hit,
  output logic [SID_W-1:0]       ded_sid
);
  logic [NSYM-1:0][CNT_W-1:0]  cnt_q;
  logic [NSYM-1:0][CNT_W-1:0]  cnt_nx;
  logic [NSYM-1:0]             sym_inc;
  logic [LVL_W-1:0]            lvl_q;
  logic [LVL_W-1:0]            lvl_nx;
  logic [NFEAT-1:0][CNT_W-1:0] feat_q;

  for (genvar k = 0; k < NSYM; k++) begin : g_sym
    if (k < NTRAP) begin : g_trap
      assign sym_inc[k] = trap_valid && (trap_code == TRACKED[k]);
    end else begin : g_busy
      assign sym_inc[k] = busy_pulse;
    end
    symg_sat_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc    (sym_inc[k]),
      .clr    (win_end),
      .cnt_q  (cnt_q[k]),
      .cnt_nx (cnt_nx[k])
    );
  end

  symg_nest_track u_nest (
    .clk    (clk),
    .rst    (rst),
    .ev     (trap_valid),
    .depth  (trap_depth),
    .clr    (win_end),
    .lvl_q  (lvl_q),
    .lvl_nx (lvl_nx)
  );

  symg_ded_cam #(.DEPTH(TBL_DEPTH)) u_cam (
    .clk       (clk),
    .rst       (rst),
    .we        (tbl_we),
    .waddr     (tbl_idx),
    .wcode     (tbl_code),
    .wsid      (tbl_sid),
    .wvalid    (tbl_valid),
    .look_en   (trap_valid),
    .look_code (trap_code),
    .hit_q     (ded_hit),
    .sid_q     (ded_sid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      feat_q     <= '0;
      feat_valid <= 1'b0;
    end else begin
      feat_valid <= win_end;
      if (win_end) begin
        for (int k = 0; k < NSYM; k++) feat_q[k] <= cnt_nx[k];
        feat_q[NSYM] <= CNT_W'(lvl_nx);
      end
    end
  end

  assign feat_vec = feat_q;

  assert_win_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    feat_valid |-> $past(win_end));
  assert_feat_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(feat_vec));
  assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (rst)
    win_end |=> cnt_q == '0);
endmodule

// File: tb/symptom_gather_test.sv
module symptom_gather_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        trap_valid, busy_pulse, win_end, tbl_we, tbl_valid;
  logic [7:0]  trap_code, tbl_code;
  logic [2:0]  trap_depth, tbl_idx;
  logic [1:0]  tbl_sid;
  logic [63:0] feat_vec;
  logic        feat_valid, ded_hit;
  logic [1:0]  ded_sid;

  int tests = 0, fails = 0;
  bit done = 0;

  // Reference model state
  int       cnt [7];
  int       lvl;
  int       efeat [8];
  bit       efv, ehit;
  int       esid;
  bit       mv [8];
  bit [7:0] mc [8];
  bit [1:0] ms [8];

  always #(CLK_P/2) clk = ~clk;

  symptom_gather uut (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_code(trap_code),
    .trap_depth(trap_depth), .busy_pulse(busy_pulse), .win_end(win_end),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_code(tbl_code), .tbl_sid(tbl_sid),
    .tbl_valid(tbl_valid), .feat_vec(feat_vec), .feat_valid(feat_valid),
    .ded_hit(ded_hit), .ded_sid(ded_sid)
  );

  function automatic int tracked_idx(input bit [7:0] c);
    case (c)
      8'h10: return 0;
      8'h34: return 1;
      8'h28: return 2;
      8'h30: return 3;
      8'h02: return 4;
      8'h05: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R9", "ded_hit", ded_hit, ehit);
    chk(ehit ? "R9" : "R10", "ded_sid", ded_sid, esid);
    chk("R5", "feat_valid", feat_valid, efv);
    for (int k = 0; k < 8; k++)
      chk(k < 6 ? "R2" : (k == 6 ? "R3" : "R6"), $sformatf("feat[%0d]", k),
          feat_vec[k*8 +: 8], efeat[k]);
  endtask

  task automatic step(input bit tv, input bit [7:0] code, input bit [2:0] dep,
                      input bit busy, input bit win, input bit we,
                      input bit [2:0] wa, input bit [7:0] wc, input bit [1:0] ws,
                      input bit wv);
    int ti, d, nl;
    trap_valid = tv; trap_code = code; trap_depth = dep; busy_pulse = busy;
    win_end = win; tbl_we = we; tbl_idx = wa; tbl_code = wc; tbl_sid = ws;
    tbl_valid = wv;
    @(posedge clk);
    ehit = 0; esid = 0;
    if (tv)
      for (int i = 0; i < 8; i++)
        if (!ehit && mv[i] && mc[i] == code) begin ehit = 1; esid = ms[i]; end
    if (we) begin mv[wa] = wv; mc[wa] = wc; ms[wa] = ws; end
    ti = tracked_idx(code);
    if (tv && ti >= 0) cnt[ti] = sat(cnt[ti] + 1);
    if (busy) cnt[6] = sat(cnt[6] + 1);
    nl = lvl;
    if (tv) begin d = (dep > 6) ? 6 : dep; if (d > nl) nl = d; end
    if (win) begin
      for (int k = 0; k < 7; k++) begin efeat[k] = cnt[k]; cnt[k] = 0; end
      efeat[7] = nl; lvl = 0; efv = 1;
    end else begin
      lvl = nl; efv = 0;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic trap(input bit [7:0] c, input bit [2:0] d);
    step(1, c, d, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic twrite(input bit [2:0] a, input bit [7:0] c, input bit [1:0] s, input bit v);
    step(0, 0, 0, 0, 0, 1, a, c, s, v);
  endtask

  task automatic close_win();
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 7; k++) cnt[k] = 0;
    for (int k = 0; k < 8; k++) begin efeat[k] = 0; mv[k] = 0; mc[k] = 0; ms[k] = 0; end
    lvl = 0; efv = 0; ehit = 0; esid = 0;
    rst = 1;
    trap_valid = 0; trap_code = 0; trap_depth = 0; busy_pulse = 0; win_end = 0;
    tbl_we = 0; tbl_idx = 0; tbl_code = 0; tbl_sid = 0; tbl_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "feat_vec", int'(feat_vec != 0), 0);
    chk("R1", "feat_valid", feat_valid, 0);
    chk("R1", "ded_hit", ded_hit, 0);
    rst = 0;
    idle();
    // R1: table empty after reset, so a trap matches nothing
    trap(8'h10, 3'd1);
    chk("R1", "empty table hit", ded_hit, 0);

    // R2: untracked codes only, then close window
    trap(8'h99, 3'd0); trap(8'h11, 3'd0);
    close_win();
    chk("R2", "untracked elem0", feat_vec[7:0], 1);

    // R3: trap and busy in same cycle; R5: events in strobe cycle counted
    step(1, 8'h34, 3'd2, 1, 0, 0, 0, 0, 0, 0);
    step(1, 8'h34, 3'd1, 1, 1, 0, 0, 0, 0, 0);
    chk("R5", "strobe-cycle trap elem1", feat_vec[15:8], 2);
    chk("R3", "busy elem6", feat_vec[55:48], 2);
    idle();
    chk("R7", "hold elem1", feat_vec[15:8], 2);

    // R4: saturation
    for (int i = 0; i < 300; i++) trap(8'h10, 3'd0);
    close_win();
    chk("R4", "saturated elem0", feat_vec[7:0], 255);
    chk("R5", "restart elem0", cnt[0], 0);

    // R6: depth clamp and empty window level
    trap(8'h28, 3'd7);
    close_win();
    chk("R6", "clamp level", feat_vec[63:56], 6);
    close_win();
    chk("R6", "empty level", feat_vec[63:56], 0);

    // R8/R9: table writes, duplicate codes, priority
    twrite(3'd5, 8'h44, 2'd1, 1);
    twrite(3'd2, 8'h44, 2'd2, 1);
    twrite(3'd3, 8'h21, 2'd0, 0);
    trap(8'h44, 3'd0);
    chk("R9", "priority sid", ded_sid, 2);
    trap(8'h21, 3'd0);
    chk("R8", "invalid entry hit", ded_hit, 0);
    // R8: same-cycle write and trap uses old contents
    step(1, 8'h66, 3'd0, 0, 0, 1, 3'd6, 8'h66, 2'd1, 1);
    chk("R8", "same-cycle hit", ded_hit, 0);
    trap(8'h66, 3'd0);
    chk("R8", "after write hit", ded_hit, 1);
    chk("R9", "after write sid", ded_sid, 1);
    idle();
    chk("R10", "no trap hit", ded_hit, 0);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      bit [7:0] c;
      int sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2, 3: c = 8'(tracked_idx(8'h10) == 0 ?
                      (sel == 0 ? 8'h10 : sel == 1 ? 8'h34 : sel == 2 ? 8'h30 : 8'h05) : 8'h00);
        4: c = 8'h28;
        5: c = 8'h02;
        6, 7: c = mc[$urandom_range(0, 7)];
        default: c = 8'($urandom);
      endcase
      step($urandom_range(0, 99) < 40, c, 3'($urandom_range(0, 7)),
           $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 4,
           $urandom_range(0, 99) < 3, 3'($urandom_range(0, 7)), 8'($urandom),
           2'($urandom_range(0, 2)), $urandom_range(0, 3) != 0);
    end
    close_win();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule